// File: doc/BRIEF.md
# Transceiver Mode Control Register

This block holds the operating-state selection for a fault-tolerant CAN physical layer and reports the state the transceiver actually runs in, together with a latched overtemperature flag. Host software writes a three-bit state code through the serial register interface and reads back one byte that carries the effective state and the thermal flag.

The effective state is not only what software wrote. A forced-termination request from the supply mode logic overrides the written code at once. It also wipes the two low code bits, so the transceiver stays parked in termination-to-battery after the request goes away, until software writes again. The overtemperature input passes through a parameterised synchroniser into a sticky flag that a read clears. The two reset inputs behave differently: power-on reset clears everything, while the external reset only freezes host access and leaves the register contents alone.

Top module: `xcvr_mode_reg`

## Requirements
- R1: The state codes are 3'b000 termination-to-battery, 3'b010 receive-only and 3'b011 full receive/transmit. A write of a listed code with no forced termination shows on `xcvr_state` after the write's clock edge.
- R2: A written code that is not listed (001, 100, 101, 110, 111) makes `xcvr_state` read 3'b000.
- R3: A read returns a byte with the effective state in bits 2:0, the latched overtemperature flag in bit 3 and zeros in bits 7:4. The byte is captured at the read's clock edge and held on `rd_data` until the next accepted read.
- R4: While `force_term` is high, `xcvr_state` is 3'b000 in the same cycle. The edge that samples it clears code bits 1:0, so the state stays 3'b000 after the request drops until a new write.
- R5: The overtemperature flag sets once `ovt_in` has been high for SYNC_STAGES+1 clock edges. It stays set after `ovt_in` falls.
- R6: An accepted read clears the flag. If the synchronised condition is still present at that edge, the flag stays set.
- R7: Power-on reset (`por_n` low) clears the code, the flag and `rd_data`, giving `xcvr_state` 3'b000 and `rd_data` 8'h00.
- R8: While `ext_rst_n` is low, writes and reads are ignored. The code, the flag and `rd_data` keep their values, and `xcvr_state` does not change.
- R9: When a write and `force_term` share an edge, the forced clear wins for code bits 1:0, and the state remains 3'b000 once the request ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| ext_rst_n | input | 1 | External reset, active low; blocks host access only |
| wr_en | input | 1 | Write strobe for the state code |
| rd_en | input | 1 | Read strobe; captures and clears the flag |
| wr_code | input | 3 | State code to write |
| force_term | input | 1 | Forced termination request from supply mode logic |
| ovt_in | input | 1 | Raw transceiver overtemperature condition |
| xcvr_state | output | 3 | Effective transceiver state |
| rd_data | output | DATA_W | Read-back byte |

## Verification
The bench builds the block with its defaults: an 8-bit read byte, the flag at bit 3, a two-stage synchroniser and the registered read path. The two synchroniser stages put three edges between `ovt_in` and the flag. That separates the flag's hold from the raw input, and it lets a read land while the condition is still in the pipeline, so the re-set-on-clear case can be reached. The registered read path makes the hold of `rd_data` across ignored reads visible during external reset.

// File: rtl/xcvr_mode_pkg.sv
package xcvr_mode_pkg;

   localparam int XM_CODE_W = 3;

   typedef enum logic [XM_CODE_W-1:0] {
      XM_TERM   = 3'b000,
      XM_RXONLY = 3'b010,
      XM_FULL   = 3'b011
   } xm_state_e;

   function automatic logic [XM_CODE_W-1:0] xm_decode(input logic [XM_CODE_W-1:0] code);
      logic [XM_CODE_W-1:0] res;
      case (code)
         XM_RXONLY: res = XM_RXONLY;
         XM_FULL:   res = XM_FULL;
         default:   res = XM_TERM;
      endcase
      return res;
   endfunction

endpackage

// File: rtl/xcvr_mode_ctrl_reg.sv
module xcvr_mode_ctrl_reg
   import xcvr_mode_pkg::*;
(
   input  logic                 clk,
   input  logic                 por_n,
   input  logic                 acc_en,
   input  logic                 wr_en,
   input  logic [XM_CODE_W-1:0] wr_code,
   input  logic                 force_term,
   output logic [XM_CODE_W-1:0] code_q
);

   logic [XM_CODE_W-1:0] code_d;

   always_comb begin
      code_d = code_q;
      if (acc_en && wr_en) begin
         code_d = wr_code;
      end
      if (force_term) begin
         code_d[1:0] = 2'b00;
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         code_q <= '0;
      end else begin
         code_q <= code_d;
      end
   end

endmodule

// File: rtl/xcvr_ovt_latch.sv
module xcvr_ovt_latch #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic por_n,
   input  logic ovt_raw,
   input  logic clr,
   output logic ovt_q
);

   logic ovt_sync;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign ovt_sync = ovt_raw;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] chain;
      for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
               chain[i] <= 1'b0;
            end else if (i == 0) begin
               chain[i] <= ovt_raw;
            end else begin
               chain[i] <= chain[(i == 0) ? 0 : i-1];
            end
         end
      end
      assign ovt_sync = chain[SYNC_STAGES-1];
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         ovt_q <= 1'b0;
      end else begin
         ovt_q <= ovt_sync | (ovt_q & ~clr);
      end
   end

endmodule

// File: rtl/xcvr_readback.sv
module xcvr_readback
   import xcvr_mode_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int OVT_POS  = 3,
   parameter bit REG_READ = 1'b1
) (
   input  logic                 clk,
   input  logic                 por_n,
   input  logic                 rd_fire,
   input  logic [XM_CODE_W-1:0] state,
   input  logic                 ovt,
   output logic [DATA_W-1:0]    rd_data
);

   logic [DATA_W-1:0] image;

   always_comb begin
      image                  = '0;
      image[XM_CODE_W-1:0]   = state;
      image[OVT_POS]         = ovt;
   end

   if (REG_READ) begin : g_reg
      logic [DATA_W-1:0] rd_q;
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n) begin
            rd_q <= '0;
         end else if (rd_fire) begin
            rd_q <= image;
         end
      end
      assign rd_data = rd_q;
   end else begin : g_comb
      assign rd_data = image;
   end

endmodule

// File: rtl/xcvr_mode_reg.sv
module xcvr_mode_reg
   import xcvr_mode_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int OVT_POS     = 3,
   parameter int SYNC_STAGES = 2,
   parameter bit REG_READ    = 1'b1
) (
   input  logic                 clk,
   input  logic                 por_n,
   input  logic                 ext_rst_n,
   input  logic                 wr_en,
   input  logic                 rd_en,
   input  logic [XM_CODE_W-1:0] wr_code,
   input  logic                 force_term,
   input  logic                 ovt_in,
   output logic [XM_CODE_W-1:0] xcvr_state,
   output logic [DATA_W-1:0]    rd_data
);

   if (OVT_POS < XM_CODE_W) begin : g_bad_ovt_low
      $error("OVT_POS overlaps the state field");
   end
   if (OVT_POS >= DATA_W) begin : g_bad_ovt_high
      $error("OVT_POS outside the read byte");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES must be 0 to 4");
   end

   logic                 acc_en;
   logic                 rd_fire;
   logic [XM_CODE_W-1:0] code_q;
   logic                 ovt_q;

   assign acc_en  = ext_rst_n;
   assign rd_fire = acc_en & rd_en;

   xcvr_mode_ctrl_reg i_ctrl (
      .clk        (clk),
      .por_n      (por_n),
      .acc_en     (acc_en),
      .wr_en      (wr_en),
      .wr_code    (wr_code),
      .force_term (force_term),
      .code_q     (code_q)
   );

   assign xcvr_state = force_term ? XM_TERM : xm_decode(code_q);

   xcvr_ovt_latch #(
      .SYNC_STAGES (SYNC_STAGES)
   ) i_ovt (
      .clk     (clk),
      .por_n   (por_n),
      .ovt_raw (ovt_in),
      .clr     (rd_fire),
      .ovt_q   (ovt_q)
   );

   xcvr_readback #(
      .DATA_W   (DATA_W),
      .OVT_POS  (OVT_POS),
      .REG_READ (REG_READ)
   ) i_rb (
      .clk     (clk),
      .por_n   (por_n),
      .rd_fire (rd_fire),
      .state   (xcvr_state),
      .ovt     (ovt_q),
      .rd_data (rd_data)
   );

endmodule

// File: rtl/xcvr_mode_reg_chk.sv
module xcvr_mode_reg_chk
   import xcvr_mode_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int OVT_POS  = 3,
   parameter bit REG_READ = 1'b1
) (
   input logic                 clk,
   input logic                 por_n,
   input logic                 ext_rst_n,
   input logic                 wr_en,
   input logic                 rd_en,
   input logic                 force_term,
   input logic [XM_CODE_W-1:0] xcvr_state,
   input logic [DATA_W-1:0]    rd_data
);

   localparam logic [DATA_W-1:0] USED_MASK =
      (DATA_W'(1) << OVT_POS) | DATA_W'((1 << XM_CODE_W) - 1);

   p_state_legal_r1: assert property (@(posedge clk) disable iff (!por_n)
      xcvr_state == XM_TERM || xcvr_state == XM_RXONLY || xcvr_state == XM_FULL);

   p_pad_zero_r3: assert property (@(posedge clk) disable iff (!por_n)
      (rd_data & ~USED_MASK) == '0);

   p_force_now_r4: assert property (@(posedge clk) disable iff (!por_n)
      force_term |-> xcvr_state == XM_TERM);

   p_force_clears_r4: assert property (@(posedge clk) disable iff (!por_n)
      force_term |=> xcvr_state == XM_TERM);

   p_force_beats_write_r9: assert property (@(posedge clk) disable iff (!por_n)
      (force_term && wr_en) |=> xcvr_state == XM_TERM);

   p_ext_hold_r8: assert property (@(posedge clk) disable iff (!por_n)
      (!ext_rst_n && !force_term) ##1 !force_term |-> $stable(xcvr_state));

   if (REG_READ) begin : g_rd_hold
      p_rd_hold_r3: assert property (@(posedge clk) disable iff (!por_n)
         !(rd_en && ext_rst_n) |=> $stable(rd_data));
   end

   always @(posedge clk) begin
      if (!por_n) begin
         p_por_clear_r7: assert (xcvr_state == XM_TERM && rd_data == '0);
      end
   end

endmodule

bind xcvr_mode_reg xcvr_mode_reg_chk #(
   .DATA_W   (DATA_W),
   .OVT_POS  (OVT_POS),
   .REG_READ (REG_READ)
) i_chk (
   .clk        (clk),
   .por_n      (por_n),
   .ext_rst_n  (ext_rst_n),
   .wr_en      (wr_en),
   .rd_en      (rd_en),
   .force_term (force_term),
   .xcvr_state (xcvr_state),
   .rd_data    (rd_data)
);

// File: tb/test_xcvr_mode_reg.sv
module test_xcvr_mode_reg;

   logic       clk = 1'b0;
   logic       por_n;
   logic       ext_rst_n;
   logic       wr_en;
   logic       rd_en;
   logic [2:0] wr_code;
   logic       force_term;
   logic       ovt_in;
   logic [2:0] xcvr_state;
   logic [7:0] rd_data;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   xcvr_mode_reg i_xcvr_mode_reg (
      .clk        (clk),
      .por_n      (por_n),
      .ext_rst_n  (ext_rst_n),
      .wr_en      (wr_en),
      .rd_en      (rd_en),
      .wr_code    (wr_code),
      .force_term (force_term),
      .ovt_in     (ovt_in),
      .xcvr_state (xcvr_state),
      .rd_data    (rd_data)
   );

   // entry: {wr_en, force_term, wr_code[2:0], expected state[2:0]}
   localparam int NVEC = 14;
   localparam logic [7:0] VEC [NVEC] = '{
      8'b1_0_000_000,   // R1 termination
      8'b1_0_010_010,   // R1 receive-only
      8'b1_0_011_011,   // R1 full
      8'b1_0_001_000,   // R2 unlisted
      8'b1_0_111_000,   // R2 unlisted
      8'b1_0_110_000,   // R2 unlisted
      8'b1_0_100_000,   // R2 unlisted
      8'b1_0_011_011,   // R1 full again
      8'b0_1_000_000,   // R4 forced now
      8'b0_0_000_000,   // R4 stays parked
      8'b1_0_010_010,   // R1 receive-only
      8'b1_1_011_000,   // R9 force and write together
      8'b0_0_000_000,   // R9 write lost
      8'b1_0_011_011    // R1 recover
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic do_read();
      rd_en = 1'b1;
      tick();
      rd_en = 1'b0;
   endtask

   task automatic ovt_pulse();
      ovt_in = 1'b1;
      repeat (4) tick();
      ovt_in = 1'b0;
      repeat (3) tick();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      por_n = 1'b1; ext_rst_n = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
      wr_code = 3'b000; force_term = 1'b0; ovt_in = 1'b0;
      #1 por_n = 1'b0;
      repeat (3) tick();
      chk("R7 reset state", {5'b0, xcvr_state}, 8'h00);
      chk("R7 reset rd_data", rd_data, 8'h00);
      por_n = 1'b1;
      tick();

      for (int i = 0; i < NVEC; i++) begin
         wr_en      = VEC[i][7];
         force_term = VEC[i][6];
         wr_code    = VEC[i][5:3];
         tick();
         chk($sformatf("R1 R2 R4 R9 vector %0d", i), {5'b0, xcvr_state}, {5'b0, VEC[i][2:0]});
      end
      wr_en = 1'b0; force_term = 1'b0;

      // R5 latch and hold; R6 clear on read
      ovt_pulse();
      do_read();
      chk("R3 R5 read with flag", rd_data, 8'h0B);
      do_read();
      chk("R6 flag cleared", rd_data, 8'h03);
      repeat (3) tick();
      chk("R3 rd_data held", rd_data, 8'h03);

      // R6 condition present while reading
      ovt_in = 1'b1;
      repeat (4) tick();
      do_read();
      chk("R6 first read", rd_data, 8'h0B);
      do_read();
      chk("R6 re-set during clear", rd_data, 8'h0B);
      ovt_in = 1'b0;
      repeat (3) tick();
      do_read();
      chk("R5 held after input fell", rd_data, 8'h0B);
      do_read();
      chk("R6 cleared after fall", rd_data, 8'h03);

      // R8 external reset freezes access
      ext_rst_n = 1'b0;
      wr_en = 1'b1; wr_code = 3'b010;
      tick();
      wr_en = 1'b0;
      chk("R8 write ignored", {5'b0, xcvr_state}, 8'h03);
      ovt_pulse();
      do_read();
      chk("R8 read ignored", rd_data, 8'h03);
      ext_rst_n = 1'b1;
      tick();
      do_read();
      chk("R8 flag kept after ignored read", rd_data, 8'h0B);

      // R7 power-on reset mid-run
      ovt_pulse();
      por_n = 1'b0;
      tick();
      chk("R7 state cleared", {5'b0, xcvr_state}, 8'h00);
      chk("R7 rd_data cleared", rd_data, 8'h00);
      por_n = 1'b1;
      tick();
      do_read();
      chk("R7 flag cleared", rd_data, 8'h00);

      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

endmodule